// File: doc/BRIEF.md
# Software-Filled Translation Buffer

This block is a set-associative address translation cache. The operating system fills it and inspects it through three control registers. The first is an entry register that holds a frame number and permission flags. The second is a page register that holds a virtual page number. The third is a control register that holds the process ID, a way pointer, a write-enable bit and a read trigger. Writing the entry register while write-enable is set commits an entry to the way named by the pointer. The entry goes into the set selected by the low bits of the page register, and the pointer then steps to the next way. Writing the control register with the read trigger set copies the selected entry back into the entry register, so software can inspect it.

A separate combinational lookup port takes a virtual page number, a process ID and an access kind. It returns hit, frame number, cacheable, a permission fault and a multiple-match flag. Entries marked global match on the page number alone. Page-table walking, exception raising and caching are left to the surrounding design.

Top module: `soft_tlb`

## Requirements
- R1: After reset, all three registers read zero and no lookup hits, because every valid bit is cleared.
- R2: A write to the entry register (sel 0) while write-enable is set stores the written frame number and flags, the page register's page number and the control register's process ID. The entry goes into way `way` of set `vpn[3:0]`, and later lookups that match it return that frame number and the cacheable flag.
- R3: Each committed entry write advances the way field (control bits 9:8) by one, and the field wraps from 3 to 0.
- R4: A write to the entry register while write-enable is clear stores no entry and leaves the way field unchanged. The entry register itself still takes the value.
- R5: A control-register write (sel 2) with bit 10 set loads the entry at the written way and the page register's set into the entry register. Bit 10 always reads back as 0.
- R6: Entry register layout: frame number in bits 19:0, C bit 20, R bit 21, W bit 22, X bit 23, G bit 24. Bits 31:25 are discarded on write and read as zero. Page register: page number in bits 19:0. Control register: process ID in bits 7:0, way in bits 9:8, read trigger in bit 10, write-enable in bit 11. Register select 3 reads zero.
- R7: A lookup matches a valid entry when the page numbers are equal and either the entry's G flag is 1 or the process IDs are equal.
- R8: Lookup kind 0 (load) faults without R, kind 1 (store) faults without W, and kind 2 (fetch) faults without X. Kind 3 never faults, and no lookup faults on a miss.
- R9: When several ways match, the lowest-numbered one supplies the outputs and the multi-hit flag is raised. The flag is low for zero or one match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 entry, 1 page, 2 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read of the selected register |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_pid | input | 8 | Lookup process ID |
| lk_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lk_hit | output | 1 | A valid entry matched |
| lk_pfn | output | 20 | Frame number of the winning entry |
| lk_cache | output | 1 | Cacheable flag of the winning entry |
| lk_fault | output | 1 | Permission missing for this access kind |
| lk_multi | output | 1 | More than one way matched |

## Verification
Four rules are checked by assertions on every cycle. A fault or multi-hit never appears without a hit. The read trigger and the discarded upper bits always read as zero. The way pointer steps exactly once per committed write and holds on an uncommitted one. What only the bench scenarios can show is what the entries contain and how they are used. That covers which entry lands where, process-ID versus global matching, lowest-way priority, permission decoding per access kind and readback through the read trigger. The bench checks these against a reference model driven by seeded random register traffic, plus directed corner cases.

// File: rtl/soft_tlb.sv
module soft_tlb #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  parameter int PFN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [PID_W-1:0] lk_pid,
  input  logic [1:0]       lk_kind,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_cache,
  output logic             lk_fault,
  output logic             lk_multi
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int SET_W = $clog2(SETS);
  localparam int ENT_W = PFN_W + 5;
  localparam int F_C   = PFN_W;
  localparam int F_R   = PFN_W + 1;
  localparam int F_W   = PFN_W + 2;
  localparam int F_X   = PFN_W + 3;
  localparam int F_G   = PFN_W + 4;
  localparam int M_WAY = PID_W;
  localparam int M_RD  = PID_W + WAY_W;
  localparam int M_WE  = M_RD + 1;

  logic [ENT_W-1:0] acc_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PID_W-1:0] pid_q;
  logic [WAY_W-1:0] way_q;
  logic             we_q;

  logic [ENT_W-1:0] e_data [WAYS][SETS];
  logic [VPN_W-1:0] e_vpn  [WAYS][SETS];
  logic [PID_W-1:0] e_pid  [WAYS][SETS];
  logic             e_val  [WAYS][SETS];

  wire [SET_W-1:0] wset   = vpn_q[SET_W-1:0];
  wire [WAY_W-1:0] rd_way = reg_wdata[M_WAY +: WAY_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      vpn_q <= '0;
      pid_q <= '0;
      way_q <= '0;
      we_q  <= 1'b0;
      for (int w = 0; w < WAYS; w++)
        for (int s = 0; s < SETS; s++) begin
          e_data[w][s] <= '0;
          e_vpn[w][s]  <= '0;
          e_pid[w][s]  <= '0;
          e_val[w][s]  <= 1'b0;
        end
    end else if (reg_we) begin
      case (reg_sel)
        2'd0: begin
          acc_q <= reg_wdata[ENT_W-1:0];
          if (we_q) begin
            e_data[way_q][wset] <= reg_wdata[ENT_W-1:0];
            e_vpn[way_q][wset]  <= vpn_q;
            e_pid[way_q][wset]  <= pid_q;
            e_val[way_q][wset]  <= 1'b1;
            way_q <= (way_q == WAY_W'(WAYS-1)) ? '0 : way_q + 1'b1;
          end
        end
        2'd1: vpn_q <= reg_wdata[VPN_W-1:0];
        2'd2: begin
          pid_q <= reg_wdata[PID_W-1:0];
          way_q <= rd_way;
          we_q  <= reg_wdata[M_WE];
          if (reg_wdata[M_RD]) acc_q <= e_data[rd_way][wset];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {{(32-ENT_W){1'b0}}, acc_q};
      2'd1:    reg_rdata = {{(32-VPN_W){1'b0}}, vpn_q};
      2'd2:    reg_rdata = {{(31-M_WE){1'b0}}, we_q, 1'b0, way_q, pid_q};
      default: reg_rdata = '0;
    endcase
  end

  wire [SET_W-1:0] lset = lk_vpn[SET_W-1:0];
  logic [WAY_W-1:0] hit_way;
  int               n_match;
  logic [ENT_W-1:0] hit_ent;

  always_comb begin
    hit_way = '0;
    n_match = 0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (e_val[w][lset] && e_vpn[w][lset] == lk_vpn &&
          (e_data[w][lset][F_G] || e_pid[w][lset] == lk_pid)) begin
        hit_way = WAY_W'(w);
        n_match = n_match + 1;
      end
    end
  end

  assign hit_ent  = e_data[hit_way][lset];
  assign lk_hit   = n_match != 0;
  assign lk_multi = n_match > 1;
  assign lk_pfn   = lk_hit ? hit_ent[PFN_W-1:0] : '0;
  assign lk_cache = lk_hit & hit_ent[F_C];

  always_comb begin
    case (lk_kind)
      2'd0:    lk_fault = lk_hit & ~hit_ent[F_R];
      2'd1:    lk_fault = lk_hit & ~hit_ent[F_W];
      2'd2:    lk_fault = lk_hit & ~hit_ent[F_X];
      default: lk_fault = 1'b0;
    endcase
  end
endmodule

module soft_tlb_chk #(parameter int WAY_W = 2) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [1:0]       reg_sel,
  input logic [31:0]      reg_rdata,
  input logic             lk_hit,
  input logic             lk_fault,
  input logic             lk_multi,
  input logic [WAY_W-1:0] way,
  input logic             we_en
);
  p_fault_on_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);
  p_multi_on_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit);
  p_rd_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd2) |-> !reg_rdata[WAY_W+8]);
  p_ig_bits_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd0) |-> reg_rdata[31:25] == 7'd0);
  p_way_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd0 && we_en) |=> way == WAY_W'($past(way) + 1'b1));
  p_way_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd0 && !we_en) |=> $stable(way));
endmodule

bind soft_tlb soft_tlb_chk #(.WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_rdata(reg_rdata), .lk_hit(lk_hit), .lk_fault(lk_fault),
  .lk_multi(lk_multi), .way(way_q), .we_en(we_q));

// File: tb/sim_soft_tlb.sv
`timescale 1ns/1ps
module sim_soft_tlb;
  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [19:0] lk_vpn = 0;
  logic [7:0] lk_pid = 0;
  logic [1:0] lk_kind = 0;
  logic lk_hit, lk_cache, lk_fault, lk_multi;
  logic [19:0] lk_pfn;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  soft_tlb u0 (.*);

  logic [24:0] m_data [4][16];
  logic [19:0] m_vpn [4][16];
  logic [7:0]  m_pid [4][16];
  bit          m_val [4][16];
  logic [24:0] m_acc;
  logic [19:0] m_pg;
  logic [7:0]  m_id;
  logic [1:0]  m_way;
  bit          m_we;

  bit ex_hit, ex_cache, ex_fault, ex_multi;
  logic [19:0] ex_pfn;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = s; reg_wdata = d;
    case (s)
      2'd0: begin
        m_acc = d[24:0];
        if (m_we) begin
          m_data[m_way][m_pg[3:0]] = d[24:0];
          m_vpn[m_way][m_pg[3:0]]  = m_pg;
          m_pid[m_way][m_pg[3:0]]  = m_id;
          m_val[m_way][m_pg[3:0]]  = 1;
          m_way = m_way + 2'd1;
        end
      end
      2'd1: m_pg = d[19:0];
      2'd2: begin
        m_id = d[7:0]; m_way = d[9:8]; m_we = d[11];
        if (d[10]) m_acc = m_data[d[9:8]][m_pg[3:0]];
      end
      default: ;
    endcase
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic chk_regs(input string req);
    reg_sel = 0; #1 chk(req, reg_rdata, {7'd0, m_acc});
    reg_sel = 1; #1 chk(req, reg_rdata, {12'd0, m_pg});
    reg_sel = 2; #1 chk(req, reg_rdata, {20'd0, m_we, 1'b0, m_way, m_id});
    reg_sel = 3; #1 chk(req, reg_rdata, 32'd0);
  endtask

  task automatic model_lookup(input logic [19:0] v, input logic [7:0] p, input logic [1:0] k);
    int n = 0;
    logic [24:0] e = 0;
    for (int w = 3; w >= 0; w--)
      if (m_val[w][v[3:0]] && m_vpn[w][v[3:0]] == v &&
          (m_data[w][v[3:0]][24] || m_pid[w][v[3:0]] == p)) begin
        n++; e = m_data[w][v[3:0]];
      end
    ex_hit = n > 0; ex_multi = n > 1;
    ex_pfn = ex_hit ? e[19:0] : 20'd0;
    ex_cache = ex_hit & e[20];
    ex_fault = ex_hit && ((k == 0 && !e[21]) || (k == 1 && !e[22]) || (k == 2 && !e[23]));
  endtask

  task automatic look(input string req, input logic [19:0] v, input logic [7:0] p, input logic [1:0] k);
    lk_vpn = v; lk_pid = p; lk_kind = k;
    model_lookup(v, p, k);
    #1;
    chk({req, " hit"}, lk_hit, ex_hit);
    chk({req, " pfn"}, lk_pfn, ex_pfn);
    chk({req, " cache"}, lk_cache, ex_cache);
    chk({req, " fault"}, lk_fault, ex_fault);
    chk({req, " multi"}, lk_multi, ex_multi);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 16; s++) begin
        m_data[w][s] = 0; m_vpn[w][s] = 0; m_pid[w][s] = 0; m_val[w][s] = 0;
      end
    m_acc = 0; m_pg = 0; m_id = 0; m_way = 0; m_we = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    chk_regs("R1 reset regs");
    look("R1 reset miss", 20'd0, 8'd0, 2'd0);

    wr(2, 32'h0000_0805);
    wr(1, 32'h0000_0123);
    wr(0, 32'hFE00_0000 | (1 << 21) | (1 << 20) | 32'hABC);
    chk_regs("R6 ig bits dropped, R3 way step");
    look("R2 stored entry load", 20'h123, 8'd5, 2'd0);
    look("R8 store without W", 20'h123, 8'd5, 2'd1);
    look("R7 pid mismatch miss", 20'h123, 8'd6, 2'd0);

    for (int i = 0; i < 4; i++) begin
      wr(1, 32'h0000_0300 + i);
      wr(0, (1 << 23) | (32'h100 + i));
    end
    reg_sel = 2; #1 chk("R3 way wrap", reg_rdata[9:8], 32'd1);

    wr(2, 32'h0000_0205);
    wr(1, 32'h0000_0777);
    wr(0, (1 << 21) | 32'h555);
    chk_regs("R4 no commit");
    look("R4 no entry", 20'h777, 8'd5, 2'd0);

    wr(1, 32'h0000_0123);
    wr(2, 32'h0000_0405);
    chk_regs("R5 read back entry");
    wr(2, 32'h0000_0700);
    chk_regs("R5 read way3");

    wr(2, 32'h0000_0809);
    wr(1, 32'h0000_0200);
    wr(0, (1 << 24) | (1 << 22) | 32'h777);
    look("R7 global ignores pid", 20'h200, 8'd3, 2'd1);
    look("R8 load without R", 20'h200, 8'd3, 2'd0);
    look("R8 kind3 no fault", 20'h200, 8'd3, 2'd3);

    wr(2, 32'h0000_0B09);
    wr(1, 32'h0000_0345);
    wr(0, (1 << 21) | 32'h0AA);
    wr(0, (1 << 21) | 32'h0BB);
    look("R9 lowest way wins", 20'h345, 8'd9, 2'd0);

    for (int i = 0; i < 600; i++) begin
      int op = $urandom % 6;
      case (op)
        0: wr(1, (($urandom % 3) << 4) | ($urandom % 16));
        1: wr(2, ((($urandom % 2)) << 11) | ((($urandom % 4) == 0) << 10) |
                 (($urandom % 4) << 8) | ($urandom % 4));
        2, 3: wr(0, $urandom);
        default: look("R2 R7 R8 R9 random lookup",
                      20'((($urandom % 3) << 4) | ($urandom % 16)),
                      8'($urandom % 4), 2'($urandom % 4));
      endcase
      if (i % 50 == 0) chk_regs("R5 R6 random regs");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule